// File: doc/BRIEF.md
# Idle and Sleep Power Mode Controller

This block decides whether a small processor subsystem is running, idling or sleeping. Software selects a low-power state by writing a whole byte to a power control register; only two of its bits mean anything. One bit requests idle and the other requests sleep. While idling, the controller withdraws the clock enable of the CPU core but keeps the peripheral enables (timer, serial, interrupt logic) asserted. The peripherals keep running, so a pending interrupt can end the idle state. While sleeping, every clock enable is withdrawn, and the only way out is the external reset.

In both low-power states the controller raises a port-hold signal so that output ports keep the values they had on entry. It never touches RAM contents; the memory simply keeps its data because nothing addresses it. A two-bit status output reports the current state. The enables are meant to drive clock-gating cells that sit elsewhere in the chip.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset (rst_n low), the state is run: mode_stat = 00, cpu_clk_en = 1, all periph_clk_en bits = 1, port_hold = 0.
- R2: In run, a write (wr_en = 1) with bit 0 of wr_data set and bit 1 clear gives idle from the next cycle: mode_stat = 01, cpu_clk_en = 0, all periph_clk_en bits = 1, port_hold = 1.
- R3: In run, a write with bit 1 of wr_data set gives sleep from the next cycle: mode_stat = 10, cpu_clk_en = 0, all periph_clk_en bits = 0, port_hold = 1. This holds whether bit 0 is set or clear, so sleep wins over idle.
- R4: In run, a write with bits 1 and 0 both clear leaves the state in run. Bits 7 down to 2 of wr_data have no effect.
- R5: In idle, irq_pend = 1 at a rising clock edge returns the state to run from the next cycle, with cpu_clk_en = 1 and port_hold = 0.
- R6: In sleep, irq_pend has no effect; the state stays sleep until rst_n is asserted.
- R7: While in idle or sleep, register writes are ignored.
- R8: Asserting rst_n during idle or sleep returns the state to run at once, clearing both mode requests.
- R9: In run, irq_pend has no effect on the state.
- R10: mode_stat never shows 11. cpu_clk_en is high exactly when mode_stat = 00. port_hold is high exactly when mode_stat differs from 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low external reset, also the sleep wake source |
| wr_en | input | 1 | Write strobe for the power control register |
| wr_data | input | DATA_W | Byte written; bit IDLE_BIT requests idle, bit SLEEP_BIT requests sleep |
| irq_pend | input | 1 | Some enabled interrupt is pending |
| cpu_clk_en | output | 1 | Clock enable for the CPU core |
| periph_clk_en | output | N_PERIPH | Clock enables for timer, serial and interrupt logic |
| port_hold | output | 1 | Freeze port output values |
| mode_stat | output | 2 | Current state: 00 run, 01 idle, 10 sleep |

## Verification
The bench builds the block with its default parameters: DATA_W = 8, IDLE_BIT = 0, SLEEP_BIT = 1 and N_PERIPH = 3. With a full byte on the write port, random values in the upper six bits test that only the two mode bits are decoded. The three-wide enable vector shows that every peripheral enable follows the mode. The random mix of writes, interrupts and resets reaches every transition, including a write and an interrupt in the same cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_IDLE  = 2'b01,
    PM_SLEEP = 2'b10
  } pm_mode_e;
endpackage

// File: rtl/pmc_req_decode.sv
module pmc_req_decode
  import pmc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IDLE_BIT  = 0,
  parameter int SLEEP_BIT = 1
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  pm_mode_e          cur_mode,
  output logic              req_idle,
  output logic              req_sleep
);
  logic accept;
  logic unused_data;

  // Writes only count while the core is running.
  assign accept      = wr_en && (cur_mode == PM_RUN);
  assign req_sleep   = accept && wr_data[SLEEP_BIT];
  assign req_idle    = accept && wr_data[IDLE_BIT] && !wr_data[SLEEP_BIT];
  assign unused_data = ^wr_data;
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_idle,
  input  logic     req_sleep,
  input  logic     irq_pend,
  output pm_mode_e mode_q
);
  pm_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      PM_RUN: begin
        if (req_sleep)     mode_d = PM_SLEEP;
        else if (req_idle) mode_d = PM_IDLE;
      end
      PM_IDLE:  if (irq_pend) mode_d = PM_RUN;
      PM_SLEEP: mode_d = PM_SLEEP;  // only rst_n leaves sleep
      default:  mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_RUN;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/pmc_gate_ctl.sv
module pmc_gate_ctl
  import pmc_pkg::*;
#(
  parameter int N_PERIPH = 3
) (
  input  pm_mode_e            mode,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                port_hold,
  output logic [1:0]          mode_stat
);
  logic periph_on;

  assign cpu_clk_en = (mode == PM_RUN);
  assign periph_on  = (mode != PM_SLEEP);
  assign port_hold  = (mode != PM_RUN);
  assign mode_stat  = mode;

  for (genvar g = 0; g < N_PERIPH; g++) begin : g_periph
    assign periph_clk_en[g] = periph_on;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IDLE_BIT  = 0,
  parameter int SLEEP_BIT = 1,
  parameter int N_PERIPH  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                irq_pend,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                port_hold,
  output logic [1:0]          mode_stat
);
  pm_mode_e mode_q;
  logic     req_idle;
  logic     req_sleep;

  pmc_req_decode #(
    .DATA_W(DATA_W), .IDLE_BIT(IDLE_BIT), .SLEEP_BIT(SLEEP_BIT)
  ) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .cur_mode(mode_q),
    .req_idle(req_idle), .req_sleep(req_sleep)
  );

  pmc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_sleep(req_sleep),
    .irq_pend(irq_pend), .mode_q(mode_q)
  );

  pmc_gate_ctl #(.N_PERIPH(N_PERIPH)) u_gate (
    .mode(mode_q), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .port_hold(port_hold), .mode_stat(mode_stat)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int DATA_W    = 8,
  parameter int IDLE_BIT  = 0,
  parameter int SLEEP_BIT = 1,
  parameter int N_PERIPH  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [DATA_W-1:0]   wr_data,
  input logic                irq_pend,
  input logic                cpu_clk_en,
  input logic [N_PERIPH-1:0] periph_clk_en,
  input logic                port_hold,
  input logic [1:0]          mode_stat
);
  a_r2_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b00 && wr_en && wr_data[IDLE_BIT] && !wr_data[SLEEP_BIT])
      |=> (mode_stat == 2'b01 && &periph_clk_en));

  a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b00 && wr_en && wr_data[SLEEP_BIT])
      |=> (mode_stat == 2'b10 && periph_clk_en == '0));

  a_r4_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b00 && !(wr_en && (wr_data[IDLE_BIT] || wr_data[SLEEP_BIT])))
      |=> mode_stat == 2'b00);

  a_r5_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b01 && irq_pend) |=> (mode_stat == 2'b00 && cpu_clk_en));

  a_r6_sleep_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b10) |=> mode_stat == 2'b10);

  a_r7_idle_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 2'b01 && !irq_pend) |=> mode_stat == 2'b01);

  a_r10_legal_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stat != 2'b11 && cpu_clk_en == (mode_stat == 2'b00)
      && port_hold == (mode_stat != 2'b00));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .DATA_W(DATA_W), .IDLE_BIT(IDLE_BIT), .SLEEP_BIT(SLEEP_BIT), .N_PERIPH(N_PERIPH)
) u_chk (.*);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int DATA_W = 8;
  localparam int NP     = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              irq_pend = 1'b0;
  logic              cpu_clk_en;
  logic [NP-1:0]     periph_clk_en;
  logic              port_hold;
  logic [1:0]        mode_stat;

  int checks = 0;
  int fails  = 0;
  int exp_mode = 0;  // 0 run, 1 idle, 2 sleep
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .irq_pend(irq_pend), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .port_hold(port_hold), .mode_stat(mode_stat)
  );

  function automatic int next_mode(int cur, bit we, logic [7:0] d, bit irq);
    if (cur == 0) begin
      if (we && d[1]) return 2;
      if (we && d[0]) return 1;
      return 0;
    end
    if (cur == 1) return irq ? 0 : 1;
    return 2;
  endfunction

  task automatic check(string req);
    logic [1:0]    e_stat = 2'(exp_mode);
    logic          e_cpu  = (exp_mode == 0);
    logic [NP-1:0] e_per  = (exp_mode == 2) ? '0 : '1;
    logic          e_hold = (exp_mode != 0);
    checks++;
    if (mode_stat !== e_stat || cpu_clk_en !== e_cpu ||
        periph_clk_en !== e_per || port_hold !== e_hold) begin
      fails++;
      $display("FAIL %s stat=%b cpu=%b per=%b hold=%b expected stat=%b cpu=%b per=%b hold=%b",
               req, mode_stat, cpu_clk_en, periph_clk_en, port_hold,
               e_stat, e_cpu, e_per, e_hold);
    end
  endtask

  // Drive at the falling edge, apply the model at the rising edge, check 1 ns later.
  task automatic step(bit rn, bit we, logic [7:0] d, bit irq, string req);
    @(negedge clk);
    rst_n = rn; wr_en = we; wr_data = d; irq_pend = irq;
    @(posedge clk);
    if (!rn) exp_mode = 0;
    else     exp_mode = next_mode(exp_mode, we, d, irq);
    #1;
    check(req);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    exp_mode = 0;
    check("R1 reset");
    step(0, 0, 8'h00, 0, "R1 reset held");
    step(1, 0, 8'h00, 0, "R1 after release");
    step(1, 0, 8'h00, 1, "R9 irq in run");
    step(1, 1, 8'hFC, 0, "R4 upper bits only");
    step(1, 1, 8'h01, 0, "R2 idle entry");
    step(1, 1, 8'h02, 0, "R7 write in idle");
    step(1, 0, 8'h00, 1, "R5 irq wake");
    step(1, 1, 8'h03, 0, "R3 both bits sleep wins");
    step(1, 0, 8'h00, 1, "R6 irq in sleep");
    step(1, 1, 8'h00, 1, "R7 write in sleep");
    step(0, 0, 8'h00, 0, "R8 reset from sleep");
    step(1, 1, 8'hFD, 0, "R2 idle with upper bits");
    step(0, 0, 8'h00, 1, "R8 reset from idle");
    step(1, 1, 8'h01, 1, "R2 idle entry with irq");
    step(1, 0, 8'h00, 1, "R5 wake next cycle");
    for (int i = 0; i < 3000; i++) begin
      bit rn  = ($urandom_range(0, 49) != 0);
      bit we  = $urandom_range(0, 2) == 0;
      bit irq = $urandom_range(0, 3) == 0;
      logic [7:0] d = 8'($urandom);
      string tag;
      if (!rn) tag = "R8 random reset";
      else if (exp_mode == 0) tag = "R4 random run";
      else if (exp_mode == 1) tag = "R5 random idle";
      else tag = "R6 random sleep";
      step(rn, we, d, irq, tag);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule